// File: doc/BRIEF.md
# Interrupt Link Router

This block steers eight shared PCI interrupt links onto a bank of sixteen ISA IRQ lines. Every link has a byte-wide routing register that holds a disable flag and a four-bit IRQ number. Firmware programs these registers through single-byte configuration-space accesses. Several interrupt sources report per-link raise and lower events. The router keeps a count of active sources for each link. It drives the selected IRQ line while that count is nonzero and the routing value is usable.

Rewriting a routing register moves any live interrupt at once from the old line to the new one. When two links point at the same IRQ, their requests are merged and neither cancels the other. A sixteen-bit trigger-mode register holds one bit per IRQ, where 1 means level and 0 means edge. Requests may change these bits, except for lines that must stay edge triggered. The router can also set the level bit by itself when a routing write lands on a usable IRQ.

Top module: `intlink_router`

## Requirements
- R1: After reset every routing register reads 0x80, `irq_out` and `elcr` are all zero, and `cnt_error` is low.
- R2: A single-byte write to a routing register stores the data ANDed with 0x8F (bit 7 = disable, bits 3:0 = IRQ). A read returns the stored value on `cfg_rdata` with `cfg_hit` high.
- R3: Links 0..3 sit at byte offsets 0x60..0x63 and links 4..7 at 0x68..0x6B. An access to any other offset, or an access with `cfg_single` low, gives `cfg_hit` low and changes no register.
- R4: A routing value is usable when bit 7 is clear and its IRQ is in the set 3..7, 9..12, 14..15 (mask 0xDEF8). A link with a nonzero active count and a usable value drives `irq_out[irq]` from the clock edge that accepted the event.
- R5: A link whose value is disabled, or names an IRQ outside the permitted set, drives nothing whatever its count.
- R6: Each raise event increments the link's active count and each lower event decrements it. The IRQ stays driven until the count returns to zero.
- R7: A routing write to an active link releases the old IRQ and drives the new one in the same cycle, each only if usable.
- R8: `irq_out` is the OR over all links driving each IRQ. Two active links sharing an IRQ keep it driven until both are idle.
- R9: An active count saturates at CNT_MAX. Within one cycle, a link's raises are added and capped first, and its lowers are subtracted afterwards.
- R10: A lower that would take a count below zero leaves the count at zero and sets the sticky flag `cnt_error`, which stays set until reset.
- R11: A trigger request sets (`trig_level`=1) or clears `elcr[trig_irq]`. A level request for IRQ 0, 1, 2, 8 or 13 is rejected and leaves `elcr` unchanged.
- R12: With `auto_level` high, a routing write whose stored value is usable sets `elcr` for that IRQ. A trigger request in the same cycle takes priority over this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset (read and write) |
| cfg_single | input | 1 | Access is a single byte |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the addressed routing register |
| cfg_hit | output | 1 | Offset and size decode to a routing register |
| ev_valid | input | NUM_SRC | Per-source event valid |
| ev_link | input | 3*NUM_SRC | Per-source link index |
| ev_raise | input | NUM_SRC | Per-source event kind: 1 raise, 0 lower |
| trig_valid | input | 1 | Trigger-mode request valid |
| trig_irq | input | 4 | IRQ addressed by the request |
| trig_level | input | 1 | 1 requests level, 0 requests edge |
| auto_level | input | 1 | Enable automatic level marking on routing writes |
| irq_out | output | 16 | ISA IRQ lines |
| elcr | output | 16 | Trigger mode per IRQ, 1 = level |
| cnt_error | output | 1 | Sticky count underflow flag |

## Verification
All state updates on the rising edge that samples a stimulus, so `irq_out`, `elcr` and `cnt_error` show the effect of an event, write or request one clock after it is presented. `cfg_rdata` and `cfg_hit` follow `cfg_addr` combinationally. The bench applies stimulus on the falling edge and compares the outputs against its model on the next falling edge, half a period after the update. This means every result is checked exactly one update later. Reads are checked between edges, while no write is pending.

// File: rtl/intlink_pkg.sv
package intlink_pkg;

    localparam int LINKS  = 8;
    localparam int LINK_W = 3;
    localparam int IRQS   = 16;
    localparam int IRQ_W  = 4;

    // IRQs a link may target: 3-7, 9-12, 14-15
    localparam logic [IRQS-1:0] PERMIT_MASK    = 16'hDEF8;
    // IRQs that must remain edge triggered: 0, 1, 2, 8, 13
    localparam logic [IRQS-1:0] EDGE_ONLY_MASK = 16'h2107;
    localparam logic [7:0]      ROUTE_RESET    = 8'h80;
    localparam logic [7:0]      ROUTE_KEEP     = 8'h8F;

    typedef struct packed {
        logic             off;
        logic [2:0]       pad;
        logic [IRQ_W-1:0] irq;
    } route_t;

    typedef struct packed {
        logic              hit;
        logic [LINK_W-1:0] link;
    } decode_t;

    typedef struct packed {
        logic              valid;
        logic [LINK_W-1:0] link;
        logic              raise;
    } link_evt_t;

    function automatic logic route_usable(input logic off, input logic [IRQ_W-1:0] irq);
        return !off && PERMIT_MASK[irq];
    endfunction

    function automatic logic [IRQS-1:0] irq_onehot(input logic [IRQ_W-1:0] irq);
        logic [IRQS-1:0] v;
        v = '0;
        v[irq] = 1'b1;
        return v;
    endfunction

    // Bank 0 at 0x60-0x63, bank 1 at 0x68-0x6B; only single-byte access
    function automatic decode_t decode_offset(input logic [7:0] off, input logic single);
        decode_t d;
        d.hit  = 1'b0;
        d.link = '0;
        if (single && off[7:4] == 4'h6 && off[2] == 1'b0) begin
            d.hit  = 1'b1;
            d.link = {off[3], off[1:0]};
        end
        return d;
    endfunction

endpackage

// File: rtl/intlink_route_regs.sv
module intlink_route_regs
    import intlink_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [7:0]               addr,
    input  logic                     single,
    input  logic [7:0]               wdata,
    output logic [7:0]               rd_data,
    output logic                     rd_hit,
    output route_t [LINKS-1:0]       routes,
    output logic                     upd_usable,
    output logic [IRQ_W-1:0]         upd_irq
);

    route_t [LINKS-1:0] routes_q;
    decode_t            dec;
    route_t             new_r;

    always_comb begin
        dec        = decode_offset(addr, single);
        new_r      = route_t'(wdata & ROUTE_KEEP);
        rd_hit     = dec.hit;
        rd_data    = dec.hit ? routes_q[dec.link] : 8'h00;
        upd_usable = wr_en && dec.hit && route_usable(new_r.off, new_r.irq);
        upd_irq    = new_r.irq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINKS; i++) routes_q[i] <= route_t'(ROUTE_RESET);
        end else if (wr_en && dec.hit) begin
            routes_q[dec.link] <= new_r;
        end
    end

    assign routes = routes_q;

    // R2: a decoded write lands masked in the addressed register
    a_r2_store_masked: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.hit) |=> (routes_q[$past(dec.link)] == $past(wdata & ROUTE_KEEP)));

    // R3: undecoded or multi-byte writes leave every register alone
    a_r3_miss_no_change: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !dec.hit) |=> $stable(routes_q));

endmodule

// File: rtl/intlink_count.sv
module intlink_count
    import intlink_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int CNT_W   = 3,
    parameter int CNT_MAX = 5,
    parameter int LINK_ID = 0
)(
    input  logic                       clk,
    input  logic                       rst,
    input  link_evt_t [NUM_SRC-1:0]    evts,
    output logic                       active,
    output logic                       underflow
);

    localparam int NSW   = $clog2(NUM_SRC + 1);
    localparam int SUM_W = CNT_W + NSW + 1;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [NSW-1:0]   n_inc, n_dec;
    logic [SUM_W-1:0] grown, capped;

    always_comb begin
        n_inc = '0;
        n_dec = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (evts[s].valid && evts[s].link == LINK_W'(LINK_ID)) begin
                if (evts[s].raise) n_inc = n_inc + NSW'(1);
                else               n_dec = n_dec + NSW'(1);
            end
        end
        grown     = SUM_W'(cnt_q) + SUM_W'(n_inc);
        capped    = (grown > SUM_W'(CNT_MAX)) ? SUM_W'(CNT_MAX) : grown;
        underflow = SUM_W'(n_dec) > capped;
        cnt_d     = underflow ? '0 : CNT_W'(capped - SUM_W'(n_dec));
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);

    // R9: the count never passes its ceiling
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(CNT_MAX));

    // R10: a lower on an idle link with no raise keeps the count at zero
    a_r10_floor: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && n_inc == '0 && n_dec != '0) |=> (cnt_q == '0));

    // R6: a lone raise on an idle link makes it active
    a_r6_raise_activates: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && n_inc != '0 && n_dec == '0) |=> active);

endmodule

// File: rtl/intlink_trigger.sv
module intlink_trigger
    import intlink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [IRQ_W-1:0]  req_irq,
    input  logic              req_level,
    input  logic              auto_level,
    input  logic              upd_usable,
    input  logic [IRQ_W-1:0]  upd_irq,
    output logic [IRQS-1:0]   elcr
);

    logic [IRQS-1:0] elcr_q, elcr_d;

    always_comb begin
        elcr_d = elcr_q;
        if (auto_level && upd_usable) elcr_d[upd_irq] = 1'b1;
        if (req_valid) begin
            if (!req_level)                    elcr_d[req_irq] = 1'b0;
            else if (!EDGE_ONLY_MASK[req_irq]) elcr_d[req_irq] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) elcr_q <= '0;
        else     elcr_q <= elcr_d;
    end

    assign elcr = elcr_q;

    // R11: lines that must stay edge triggered never read as level
    a_r11_edge_only_kept: assert property (@(posedge clk) disable iff (rst)
        (elcr_q & EDGE_ONLY_MASK) == '0);

    // R11: an edge request clears its bit
    a_r11_edge_clears: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_level) |=> !elcr_q[$past(req_irq)]);

    // R12: an automatic mark lands unless a request overrides that bit
    a_r12_auto_marks: assert property (@(posedge clk) disable iff (rst)
        (auto_level && upd_usable && !(req_valid && req_irq == upd_irq)) |=> elcr_q[$past(upd_irq)]);

endmodule

// File: rtl/intlink_router.sv
module intlink_router
    import intlink_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int CNT_W   = 3,
    parameter int CNT_MAX = 5
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_wr,
    input  logic [7:0]                cfg_addr,
    input  logic                      cfg_single,
    input  logic [7:0]                cfg_wdata,
    output logic [7:0]                cfg_rdata,
    output logic                      cfg_hit,
    input  logic [NUM_SRC-1:0]        ev_valid,
    input  logic [3*NUM_SRC-1:0]      ev_link,
    input  logic [NUM_SRC-1:0]        ev_raise,
    input  logic                      trig_valid,
    input  logic [3:0]                trig_irq,
    input  logic                      trig_level,
    input  logic                      auto_level,
    output logic [15:0]               irq_out,
    output logic [15:0]               elcr,
    output logic                      cnt_error
);

    route_t    [LINKS-1:0]   routes;
    link_evt_t [NUM_SRC-1:0] evts;
    logic      [LINKS-1:0]   active;
    logic      [LINKS-1:0]   under;
    logic                    upd_usable;
    logic      [IRQ_W-1:0]   upd_irq;
    logic                    err_q;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_evt
        assign evts[s].valid = ev_valid[s];
        assign evts[s].link  = ev_link[s*LINK_W +: LINK_W];
        assign evts[s].raise = ev_raise[s];
    end

    intlink_route_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_wr),
        .addr       (cfg_addr),
        .single     (cfg_single),
        .wdata      (cfg_wdata),
        .rd_data    (cfg_rdata),
        .rd_hit     (cfg_hit),
        .routes     (routes),
        .upd_usable (upd_usable),
        .upd_irq    (upd_irq)
    );

    for (genvar l = 0; l < LINKS; l++) begin : g_link
        intlink_count #(
            .NUM_SRC (NUM_SRC),
            .CNT_W   (CNT_W),
            .CNT_MAX (CNT_MAX),
            .LINK_ID (l)
        ) u_cnt (
            .clk       (clk),
            .rst       (rst),
            .evts      (evts),
            .active    (active[l]),
            .underflow (under[l])
        );
    end

    intlink_trigger u_trig (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (trig_valid),
        .req_irq    (trig_irq),
        .req_level  (trig_level),
        .auto_level (auto_level),
        .upd_usable (upd_usable),
        .upd_irq    (upd_irq),
        .elcr       (elcr)
    );

    always_comb begin
        irq_out = '0;
        for (int l = 0; l < LINKS; l++) begin
            if (active[l] && route_usable(routes[l].off, routes[l].irq))
                irq_out = irq_out | irq_onehot(routes[l].irq);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= err_q | (|under);
    end

    assign cnt_error = err_q;

    // R5: only permitted IRQ lines are ever driven
    a_r5_permitted_only: assert property (@(posedge clk) disable iff (rst)
        (irq_out & ~PERMIT_MASK) == '0);

    // R10: the error flag is sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        cnt_error |=> cnt_error);

    // R4: nothing is driven while every link is idle
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (active == '0) |-> (irq_out == '0));

endmodule

// File: tb/test_intlink_router.sv
`timescale 1ns/1ps
module test_intlink_router;

    localparam int NSRC = 3;
    localparam int CW   = 3;
    localparam int CMAX = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst;
    logic              cfg_wr;
    logic [7:0]        cfg_addr;
    logic              cfg_single;
    logic [7:0]        cfg_wdata;
    logic [7:0]        cfg_rdata;
    logic              cfg_hit;
    logic [NSRC-1:0]   ev_valid;
    logic [3*NSRC-1:0] ev_link;
    logic [NSRC-1:0]   ev_raise;
    logic              trig_valid;
    logic [3:0]        trig_irq;
    logic              trig_level;
    logic              auto_level;
    logic [15:0]       irq_out;
    logic [15:0]       elcr;
    logic              cnt_error;

    intlink_router #(.NUM_SRC(NSRC), .CNT_W(CW), .CNT_MAX(CMAX)) i_intlink_router (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_single(cfg_single), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_hit(cfg_hit), .ev_valid(ev_valid), .ev_link(ev_link),
        .ev_raise(ev_raise), .trig_valid(trig_valid), .trig_irq(trig_irq),
        .trig_level(trig_level), .auto_level(auto_level), .irq_out(irq_out),
        .elcr(elcr), .cnt_error(cnt_error)
    );

    int total = 0;
    int bad   = 0;

    logic [7:0]  mreg [8];
    int          mcnt [8];
    logic [15:0] melcr;
    logic        merr;

    function automatic logic mvalid(input logic [7:0] r);
        logic [15:0] permit;
        permit = 16'hDEF8;
        return !r[7] && permit[r[3:0]];
    endfunction

    function automatic int mdec(input logic [7:0] a, input logic single);
        if (!single) return -1;
        if (a >= 8'h60 && a <= 8'h63) return int'(a - 8'h60);
        if (a >= 8'h68 && a <= 8'h6B) return int'(a - 8'h68) + 4;
        return -1;
    endfunction

    function automatic logic [15:0] mirq();
        logic [15:0] v;
        v = '0;
        for (int l = 0; l < 8; l++)
            if (mcnt[l] != 0 && mvalid(mreg[l])) v[mreg[l][3:0]] = 1'b1;
        return v;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        cfg_wr = 0; cfg_addr = 8'h00; cfg_single = 1; cfg_wdata = 8'h00;
        ev_valid = '0; ev_link = '0; ev_raise = '0;
        trig_valid = 0; trig_irq = 4'h0; trig_level = 0;
    endtask

    task automatic model_update();
        int l;
        l = mdec(cfg_addr, cfg_single);
        if (cfg_wr && l >= 0) begin
            mreg[l] = cfg_wdata & 8'h8F;
            if (auto_level && mvalid(mreg[l])) melcr[mreg[l][3:0]] = 1'b1;
        end
        if (trig_valid) begin
            if (!trig_level) melcr[trig_irq] = 1'b0;
            else if (!(trig_irq inside {4'd0, 4'd1, 4'd2, 4'd8, 4'd13})) melcr[trig_irq] = 1'b1;
        end
        for (int k = 0; k < 8; k++) begin
            int inc, dec, g;
            inc = 0; dec = 0;
            for (int s = 0; s < NSRC; s++)
                if (ev_valid[s] && int'(ev_link[s*3 +: 3]) == k) begin
                    if (ev_raise[s]) inc++; else dec++;
                end
            g = mcnt[k] + inc;
            if (g > CMAX) g = CMAX;
            if (dec > g) begin mcnt[k] = 0; merr = 1'b1; end
            else mcnt[k] = g - dec;
        end
    endtask

    task automatic step(input string req);
        model_update();
        @(posedge clk);
        @(negedge clk);
        idle();
        check(req, "irq_out", 32'(irq_out), 32'(mirq()));
        check(req, "elcr", 32'(elcr), 32'(melcr));
        check(req, "cnt_error", 32'(cnt_error), 32'(merr));
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic single);
        int l;
        cfg_addr = a; cfg_single = single;
        #0.5;
        l = mdec(a, single);
        check(req, "cfg_hit", 32'(cfg_hit), (l >= 0) ? 32'd1 : 32'd0);
        if (l >= 0) check(req, "cfg_rdata", 32'(cfg_rdata), 32'(mreg[l]));
        cfg_addr = 8'h00; cfg_single = 1;
    endtask

    task automatic wr(input string req, input logic [7:0] a, input logic [7:0] d, input logic single);
        cfg_wr = 1; cfg_addr = a; cfg_wdata = d; cfg_single = single;
        step(req);
    endtask

    task automatic ev(input int src, input int link, input logic raise);
        ev_valid[src] = 1'b1;
        ev_link[src*3 +: 3] = 3'(link);
        ev_raise[src] = raise;
    endtask

    task automatic trig(input string req, input int irq, input logic level);
        trig_valid = 1; trig_irq = 4'(irq); trig_level = level;
        step(req);
    endtask

    task automatic read_all(input string req);
        for (int l = 0; l < 8; l++) rd(req, (l < 4) ? 8'(8'h60 + l) : 8'(8'h64 + l), 1'b1);
    endtask

    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int l = 0; l < 8; l++) begin mreg[l] = 8'h80; mcnt[l] = 0; end
        melcr = '0; merr = 0;
        auto_level = 0;
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        read_all("R1");
        check("R1", "irq_out", 32'(irq_out), 32'd0);
        check("R1", "elcr", 32'(elcr), 32'd0);
        check("R1", "cnt_error", 32'(cnt_error), 32'd0);

        // R2: masking on write, readback
        wr("R2", 8'h60, 8'hFF, 1); rd("R2", 8'h60, 1);
        wr("R2", 8'h61, 8'h75, 1); rd("R2", 8'h61, 1);

        // R3: unmapped offset and multi-byte access ignored
        wr("R3", 8'h64, 8'h05, 1);
        wr("R3", 8'h62, 8'h05, 0);
        read_all("R3");
        rd("R3", 8'h6B, 1); rd("R3", 8'h6C, 1); rd("R3", 8'h63, 0);

        // R4: usable link drives its IRQ
        wr("R4", 8'h6A, 8'h0B, 1);
        ev(0, 6, 1); step("R4");
        check("R4", "irq11", 32'(irq_out), 32'h0800);

        // R6: count holds the line until it returns to zero
        ev(1, 6, 1); step("R6");
        ev(0, 6, 0); step("R6");
        check("R6", "still_set", 32'(irq_out), 32'h0800);
        ev(1, 6, 0); step("R6");
        check("R6", "released", 32'(irq_out), 32'h0000);

        // R5: reserved IRQ and disabled link drive nothing
        wr("R5", 8'h60, 8'h0D, 1);
        wr("R5", 8'h61, 8'h85, 1);
        ev(0, 0, 1); ev(1, 1, 1); step("R5");
        check("R5", "none", 32'(irq_out), 32'h0000);

        // R7: retarget while active
        wr("R7", 8'h60, 8'h09, 1);
        check("R7", "to9", 32'(irq_out), 32'h0200);
        wr("R7", 8'h60, 8'h04, 1);
        check("R7", "to4", 32'(irq_out), 32'h0010);
        wr("R7", 8'h60, 8'h84, 1);
        check("R7", "off", 32'(irq_out), 32'h0000);

        // R8: two links sharing IRQ 10
        wr("R8", 8'h62, 8'h0A, 1);
        wr("R8", 8'h63, 8'h0A, 1);
        ev(0, 2, 1); ev(1, 3, 1); step("R8");
        ev(0, 2, 0); step("R8");
        check("R8", "shared", 32'(irq_out), 32'h0400);
        ev(0, 3, 0); step("R8");

        // R9: saturation at CMAX
        wr("R9", 8'h68, 8'h03, 1);
        for (int i = 0; i < 7; i++) begin ev(0, 4, 1); step("R9"); end
        for (int i = 0; i < CMAX - 1; i++) begin ev(0, 4, 0); step("R9"); end
        check("R9", "before_last", 32'(irq_out), 32'h0008);
        ev(0, 4, 0); step("R9");
        check("R9", "after_cap", 32'(irq_out), 32'h0000);

        // R10: lower at zero, sticky error
        wr("R10", 8'h69, 8'h07, 1);
        ev(2, 5, 0); step("R10");
        check("R10", "err", 32'(cnt_error), 32'd1);
        ev(2, 5, 1); step("R10");
        check("R10", "err_sticky", 32'(cnt_error), 32'd1);
        ev(2, 5, 0); step("R10");

        // R11: trigger requests
        trig("R11", 5, 1);
        check("R11", "lvl5", 32'(elcr), 32'h0020);
        foreach (melcr[i]) ;
        trig("R11", 13, 1); trig("R11", 0, 1); trig("R11", 1, 1);
        trig("R11", 2, 1); trig("R11", 8, 1);
        check("R11", "rejected", 32'(elcr), 32'h0020);
        trig("R11", 5, 0);
        check("R11", "edge5", 32'(elcr), 32'h0000);

        // R12: automatic level marking
        auto_level = 1;
        wr("R12", 8'h6B, 8'h0E, 1);
        check("R12", "auto14", 32'(elcr), 32'h4000);
        wr("R12", 8'h6B, 8'h08, 1);
        check("R12", "invalid_no_mark", 32'(elcr), 32'h4000);
        auto_level = 0;
        wr("R12", 8'h6B, 8'h0F, 1);
        check("R12", "off_no_mark", 32'(elcr), 32'h4000);
        auto_level = 1;
        cfg_wr = 1; cfg_addr = 8'h6B; cfg_wdata = 8'h0C; cfg_single = 1;
        trig_valid = 1; trig_irq = 4'd12; trig_level = 0;
        step("R12");
        check("R12", "request_wins", 32'(elcr[12]), 32'd0);
        auto_level = 0;

        // Random mix across R2-R12
        for (int n = 0; n < 600; n++) begin
            for (int s = 0; s < NSRC; s++)
                if ($urandom_range(0, 2) == 0) ev(s, $urandom_range(0, 7), $urandom_range(0, 1) == 1);
            if ($urandom_range(0, 3) == 0) begin
                int pick;
                pick = $urandom_range(0, 9);
                cfg_wr = 1;
                cfg_addr = (pick < 8) ? ((pick < 4) ? 8'(8'h60 + pick) : 8'(8'h64 + pick)) : 8'($urandom);
                cfg_single = ($urandom_range(0, 4) != 0);
                cfg_wdata = ($urandom_range(0, 5) == 0) ? 8'($urandom) : {4'h0, 4'($urandom)};
            end
            if ($urandom_range(0, 5) == 0) begin
                trig_valid = 1; trig_irq = 4'($urandom); trig_level = 1'($urandom);
            end
            auto_level = 1'($urandom);
            step("R8");
            if (n % 8 == 0) rd("R2", 8'($urandom_range(8'h5E, 8'h6D)), 1'b1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule